// File: doc/BRIEF.md
# Parallel Two-Level Miss Lookup Sequencer

This controller takes over once a request has missed in the first-level cache. It counts the cycles the request needs to reach the core from the levels below. After the miss is detected, the request first arbitrates for the internal address bus. It then arbitrates once for the lower levels. The second-level and third-level tag lookups start together in the same cycle. The second-level lookup ends after three cycles, and a hit there wins: the third-level outcome is then dropped. If the second level misses, the fourth lookup cycle yields the third-level outcome. A third-level hit first waits for the next rising edge of the divided external interface clock. It then spends a fixed external memory latency before the data is forwarded. The cache arrays are not part of the block; they appear only as hit flags.

Request type shapes the timing. An instruction fetch needs three bus arbitration cycles and three delivery cycles into the instruction queue. A data load needs one of each, delivering into the rename buffer. Only one request is in flight at a time. If both levels miss, a single-cycle pulse tells the bus side to fetch from memory, and no completion is signalled. A reload still in progress from an earlier second-level miss holds the new request at lower-level arbitration.

Top module: `lower_miss_sequencer`

## Requirements
- R1: Coming out of reset, `done` and `bus_miss` are low and `done_cycles` is zero.
- R2: An instruction fetch (`req_is_fetch`=1) that hits the second level raises `done` exactly 13 cycles after the accepting edge, with `done_cycles`=13.
- R3: A data load (`req_is_fetch`=0) that hits the second level raises `done` exactly 9 cycles after the accepting edge, with `done_cycles`=9.
- R4: When `l2_hit` is high in the third lookup cycle, the value of `l3_hit` has no effect on the outcome or the latency.
- R5: On a second-level miss with a third-level hit, the total latency is the third-level lookup end (10 cycles for a fetch, 8 for a load), then the alignment wait, then MEM_LAT cycles, then 1 forward cycle, then 3 delivery cycles (fetch) or 1 (load). With defaults and zero alignment this gives 37 for a fetch and 33 for a load.
- R6: The external access starts on the first cycle after the lookup in which a free-running divide-by-CLK_RATIO phase counter equals 0. That counter is 0 in the cycle after reset and advances every cycle, so the wait is 0 to CLK_RATIO-1 cycles.
- R7: When both levels miss, `bus_miss` pulses for one cycle, 10 cycles (fetch) or 8 cycles (load) after the accepting edge, and `done` stays low.
- R8: Each cycle that `reload_busy` is high while the request waits at lower-level arbitration adds one cycle to the latency. `reload_busy` has no effect in other phases.
- R9: `req_valid` is ignored while a request is in flight. It changes neither the in-flight result nor its latency, and produces no extra completion.
- R10: `done` and `bus_miss` are single-cycle pulses, never high together, and `done_cycles` holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | First-level miss request; accepted at a clock edge when idle |
| req_is_fetch | input | 1 | 1 = instruction fetch, 0 = data load |
| l2_hit | input | 1 | Second-level hit flag, sampled in the third lookup cycle |
| l3_hit | input | 1 | Third-level hit flag, sampled in the fourth lookup cycle |
| reload_busy | input | 1 | Earlier second-level miss still reloading; stalls lower-level arbitration |
| done | output | 1 | One-cycle completion strobe |
| done_cycles | output | CNT_W | Total cycles of the completed request |
| bus_miss | output | 1 | One-cycle pulse when both levels miss |

## Verification
A wrong phase count or a wrong branch at the lookup end moves the completion strobe by one or more cycles. It also changes `done_cycles` on the same strobe. Both are therefore visible within the 9 to 40 cycles of one request. A broken alignment counter gives a wrong latency only for some start phases. For that reason third-level hits are issued at every phase of the divider. A request that is not properly ignored while busy, or a lost second-level priority, shows up as an unexpected strobe or a wrong latency on the very next completion.

// File: rtl/lower_miss_sequencer.sv
module lower_miss_sequencer #(
  parameter int MEM_LAT   = 23,
  parameter int CLK_RATIO = 4,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_is_fetch,
  input  logic             l2_hit,
  input  logic             l3_hit,
  input  logic             reload_busy,
  output logic             done,
  output logic [CNT_W-1:0] done_cycles,
  output logic             bus_miss
);

  localparam int LW = $clog2(MEM_LAT + 4);
  localparam int DW = $clog2(CLK_RATIO + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DET, S_BARB, S_LARB, S_LOOK, S_ALGN, S_MEM, S_FWD, S_DLV
  } st_t;

  st_t              st;
  logic [LW-1:0]    left;
  logic [CNT_W-1:0] tot;
  logic [DW-1:0]    div;
  logic             fetch;

  wire          last       = (left == '0);
  wire [DW-1:0] div_nx     = (div == DW'(CLK_RATIO - 1)) ? '0 : div + 1'b1;
  wire          aligned_nx = (div_nx == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div <= '0;
    else        div <= div_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      left        <= '0;
      tot         <= '0;
      fetch       <= 1'b0;
      done        <= 1'b0;
      done_cycles <= '0;
      bus_miss    <= 1'b0;
    end else begin
      done     <= 1'b0;
      bus_miss <= 1'b0;
      if (st != S_IDLE) tot <= tot + 1'b1;
      case (st)
        S_IDLE:
          if (req_valid) begin
            st    <= S_DET;
            left  <= LW'(1);
            tot   <= CNT_W'(1);
            fetch <= req_is_fetch;
          end
        S_DET:
          if (last) begin
            st   <= S_BARB;
            left <= fetch ? LW'(2) : '0;
          end else left <= left - 1'b1;
        S_BARB:
          if (last) st <= S_LARB;
          else      left <= left - 1'b1;
        S_LARB:
          if (!reload_busy) begin
            st   <= S_LOOK;
            left <= LW'(3);
          end
        S_LOOK:
          if (left == LW'(1) && l2_hit) st <= S_FWD;
          else if (!last) left <= left - 1'b1;
          else if (!l3_hit) begin
            st       <= S_IDLE;
            bus_miss <= 1'b1;
          end else if (aligned_nx) begin
            st   <= S_MEM;
            left <= LW'(MEM_LAT - 1);
          end else st <= S_ALGN;
        S_ALGN:
          if (aligned_nx) begin
            st   <= S_MEM;
            left <= LW'(MEM_LAT - 1);
          end
        S_MEM:
          if (last) st <= S_FWD;
          else      left <= left - 1'b1;
        S_FWD: begin
          st   <= S_DLV;
          left <= fetch ? LW'(2) : '0;
        end
        S_DLV:
          if (last) begin
            st          <= S_IDLE;
            done        <= 1'b1;
            done_cycles <= tot;
          end else left <= left - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_excl_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && bus_miss));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_miss_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_miss |=> !bus_miss);
  assert_done_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_cycles >= CNT_W'(9)));
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LARB && reload_busy) |=> (st == S_LARB));
  assert_l2_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK && left == LW'(1) && l2_hit) |=> (st == S_FWD));
  assert_mem_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MEM && $past(st) != S_MEM) |-> (div == '0));
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && st != S_DLV && st != S_LOOK) |=> (st != S_IDLE));

endmodule

// File: tb/lower_miss_sequencer_tb.sv
module lower_miss_sequencer_tb;
  localparam int MEM = 23;
  localparam int R   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_is_fetch = 0, l2_hit = 0, l3_hit = 0, reload_busy = 0;
  logic done, bus_miss;
  logic [7:0] done_cycles;

  int checks = 0, errors = 0, ecnt = 0;
  int exp_q[$], start_q[$], req_q[$];

  lower_miss_sequencer #(.MEM_LAT(MEM), .CLK_RATIO(R), .CNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_fetch(req_is_fetch),
    .l2_hit(l2_hit), .l3_hit(l3_hit), .reload_busy(reload_busy),
    .done(done), .done_cycles(done_cycles), .bus_miss(bus_miss));

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  task automatic check(input bit ok, input int rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int exp_lat(bit f, bit h2, bit h3, int nb, int nE);
    int arb = f ? 3 : 1;
    int dl  = f ? 3 : 1;
    int stall = nb - 2 - arb;
    int c0, k;
    if (stall < 0) stall = 0;
    c0 = 2 + arb + 1 + stall + 4;
    if (h2) return c0 + dl;
    if (!h3) return -c0;
    k = c0 + 1;
    while (((nE + k - 1) % R) != 0) k++;
    return k - 1 + MEM + 1 + dl;
  endfunction

  task automatic run(input bit f, input bit h2, input bit h3, input int nb,
                     input int gap, input bit poke, input int rq);
    int nE;
    repeat (gap) @(negedge clk);
    @(negedge clk);
    req_valid = 1; req_is_fetch = f; l2_hit = h2; l3_hit = h3; reload_busy = (nb > 0);
    @(posedge clk);
    #1;
    nE = ecnt;
    req_valid = 0;
    exp_q.push_back(exp_lat(f, h2, h3, nb, nE));
    start_q.push_back(nE);
    req_q.push_back(rq);
    if (nb > 0) begin
      repeat (nb) @(posedge clk);
      @(negedge clk);
      reload_busy = 0;
    end
    if (poke) begin
      repeat (2) @(negedge clk);
      req_valid = 1; req_is_fetch = ~f;
      @(negedge clk);
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (done || bus_miss)) begin
      check(!(done && bus_miss), 10, "done and bus_miss together", {done, bus_miss}, 0);
      if (exp_q.size() == 0) begin
        check(1'b0, 9, "completion with nothing outstanding", 1, 0);
      end else begin
        int e, s, rq, lat;
        e = exp_q.pop_front(); s = start_q.pop_front(); rq = req_q.pop_front();
        lat = ecnt - s;
        if (e < 0) begin
          check(bus_miss == 1'b1, rq, "expected bus_miss kind", done, 0);
          check(lat == -e, rq, "bus_miss latency", lat, -e);
        end else begin
          check(done == 1'b1, rq, "expected done kind", bus_miss, 0);
          check(lat == e, rq, "done strobe latency", lat, e);
          check(int'(done_cycles) == e, rq, "done_cycles value", done_cycles, e);
        end
      end
    end
  end

  // R10: pulses last one cycle and done_cycles holds
  logic [7:0] held;
  always @(negedge clk) begin
    if (rst_n && done) begin
      held = done_cycles;
      @(negedge clk);
      check(!done, 10, "done pulse width", done, 0);
      check(done_cycles == held, 10, "done_cycles hold", done_cycles, held);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(done == 0, 1, "done in reset", done, 0);
    check(bus_miss == 0, 1, "bus_miss in reset", bus_miss, 0);
    check(done_cycles == 0, 1, "done_cycles in reset", done_cycles, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(done == 0 && bus_miss == 0, 1, "outputs after reset", {done, bus_miss}, 0);

    run(1, 1, 0, 0, 0, 0, 2);   // R2 fetch L2 hit -> 13
    run(0, 1, 0, 0, 0, 0, 3);   // R3 load L2 hit -> 9
    run(1, 1, 1, 0, 1, 0, 4);   // R4 l3 ignored on fetch
    run(0, 1, 1, 0, 2, 0, 4);   // R4 l3 ignored on load
    for (int g = 0; g < R; g++) begin
      run(1, 0, 1, 0, g, 0, 5); // R5 fetch from third level, every phase
      run(0, 0, 1, 0, g, 0, 6); // R6 load alignment at every phase
    end
    run(1, 0, 0, 0, 0, 0, 7);   // R7 fetch both miss
    run(0, 0, 0, 0, 3, 0, 7);   // R7 load both miss
    run(1, 1, 0, 7, 0, 0, 8);   // R8 stall 2 on fetch
    run(0, 0, 1, 5, 1, 0, 8);   // R8 stall 2 on load to third level
    run(0, 1, 0, 2, 0, 0, 8);   // R8 busy only before arbitration: no effect
    run(0, 1, 0, 0, 0, 1, 9);   // R9 request while busy ignored
    run(1, 0, 1, 0, 2, 1, 9);   // R9 ignored on a long access
    run(1, 1, 0, 0, 0, 0, 10);  // R10 back-to-back sanity
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, 9, "outstanding items at end", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule